// File: doc/BRIEF.md
# Four-wire display command engine

This block talks to a small display controller over a four-wire serial link: a clock, a data-out line, a data-in line, a chip select, and a separate pin that marks each byte as a command or a parameter. The host gives it one request at a time. A request holds a command byte, a byte count and a direction flag. On a write, the engine sends the command byte with the data/command pin low. It then takes the parameter bytes one by one from a ready/valid byte stream and sends them with the pin high. On a read, it sends the command byte and then clocks in the requested number of response bytes. Each response byte leaves the block as a one-cycle strobe. Two status commands answer with one extra leading clock. For these, the engine takes in one extra byte and moves the whole result left by one bit.

The serial clock idles low. The engine changes its output bit on falling edges and samples the input line on rising edges. The half period comes from the host input `cfg_half_div`, given in system clock cycles, and the engine adjusts it for each phase. The command byte, and any write of up to `SHORT_XFER_MAX` parameters, are kept at or below a slow ceiling. Long writes run at the host rate. Reads use the slower of a fixed read ceiling and twice the host half period. The controller runs one state machine with these states:
- IDLE waits for a request.
- CMD sends the command byte.
- PWAIT waits for the next parameter byte.
- PARAM sends that parameter byte.
- RX receives one response byte.
- FIN releases chip select and signals completion.

It has these transitions:
- IDLE to CMD when a request is accepted. A rejected request stays in IDLE and raises `err`.
- CMD to RX for a read.
- CMD to FIN for a write with no parameters.
- CMD to PWAIT for a write with parameters.
- PWAIT to PARAM when a byte arrives.
- PARAM to PWAIT while bytes remain, and PARAM to FIN after the last one.
- RX to RX while bytes remain, and RX to FIN after the last one.
- FIN to IDLE.

Top module: `dbi_cmd_engine`

## Requirements
- R1: Out of reset, chip select is high, the serial clock is low, the data/command pin is low, and `busy`, `done`, `err`, `par_ready` and `rd_valid` are all low.
- R2: The command byte goes out first, most significant bit first, with the data/command pin low. The serial clock idles low and the data-in line is sampled on rising edges.
- R3: Parameter bytes go out in the order they are supplied, with the data/command pin high and steady through each byte. A write with a count of zero ends right after the command byte.
- R4: Chip select falls once per accepted request. It stays low from the first bit of the command through the last parameter or response bit, then rises once.
- R5: A read sends the command and then receives exactly N bytes. While receiving, the data-out line is held at 0 and the data/command pin is low. Each byte is delivered on `rd_data` with a one-cycle `rd_valid`, in the order received, with the first received bit as the most significant bit.
- R6: Only these commands may take the read path: 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1, 0xA8. A write request for one of these commands is carried out as a read. A read request for any other command is rejected.
- R7: A read with N = 0 is rejected.
- R8: Commands 0x04 and 0x09 receive N+1 bytes. Output byte i equals (rx[i] << 1) | bit 7 of rx[i+1], and N bytes are delivered.
- R9: Commands 0x04 and 0x09 on the read path are rejected unless N is 3 or 4.
- R10: Let h be `cfg_half_div`, with 0 treated as 1. The command byte, and parameters of writes with N <= `SHORT_XFER_MAX` (64), have a high phase of max(`SHORT_HALF_MIN`, h) system cycles. Parameters of longer writes have a high phase of h.
- R11: Read bytes and their dummy clock have a high phase of max(`READ_HALF_MIN`, 2h) system cycles.
- R12: `busy` is high from the cycle after acceptance until completion. `done` is a single-cycle pulse at completion. A rejected request gives a single-cycle `err`, with no bus activity and `busy` left low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_cmd | input | 8 | Command byte |
| req_len | input | LEN_W | Parameter count (write) or response count (read) |
| req_rd | input | 1 | 1 asks for the read path |
| cfg_half_div | input | DIV_W | Host half period of the serial clock, in system cycles |
| par_data | input | 8 | Next parameter byte |
| par_valid | input | 1 | `par_data` is valid |
| par_ready | output | 1 | Engine is waiting for a parameter byte |
| rd_data | output | 8 | Received (realigned) response byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle reject pulse |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dc | output | 1 | Data/command pin: 0 command, 1 parameter |

## Verification
The bench models the display side bit by bit. It serves response streams with and without a leading dummy bit, and measures the high phase of every serial byte in system cycles. These are the corner cases it targets:
- The one-bit realignment of the two status commands. A design that skipped the extra byte, or shifted the wrong way, returns every byte off by one bit.
- Count boundaries: zero parameters, exactly 64 against 65 parameters, and dummy counts of 2, 3, 4 and 5. Wrong limits show up as a wrong clock width, or as a request accepted or rejected in error.
- Routing of a write request for a table command onto the read path. Getting this wrong sends the wrong bytes and gives `rd_valid` no strobes.
- A host divider of zero, which would stall a naive divider.

// File: rtl/dbi_pkg.sv
`timescale 1ns/1ps
package dbi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_PWAIT,
        ST_PARAM,
        ST_RX,
        ST_FIN
    } eng_state_t;

    typedef enum logic [1:0] {
        RATE_SHORT,
        RATE_LONG,
        RATE_READ
    } rate_cls_t;

    // Commands allowed on the receive path.
    function automatic logic is_read_cmd(input logic [7:0] c);
        logic hit;
        case (c)
            8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
            8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
            8'h56, 8'h5F, 8'hA1, 8'hA8: hit = 1'b1;
            default:                    hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Commands whose answer starts with one extra clock.
    function automatic logic has_dummy_clk(input logic [7:0] c);
        return (c == 8'h04) || (c == 8'h09);
    endfunction

endpackage

// File: rtl/dbi_rate_sel.sv
`timescale 1ns/1ps
module dbi_rate_sel
    import dbi_pkg::*;
#(
    parameter int DIV_W          = 8,
    parameter int SHORT_HALF_MIN = 10,
    parameter int READ_HALF_MIN  = 50
) (
    input  logic [DIV_W-1:0] cfg_half,
    input  rate_cls_t        cls,
    output logic [DIV_W:0]   half
);
    localparam int HW = DIV_W + 1;
    localparam logic [HW-1:0] SMIN = HW'(SHORT_HALF_MIN);
    localparam logic [HW-1:0] RMIN = HW'(READ_HALF_MIN);

    logic [HW-1:0] base;
    logic [HW-1:0] dbl;

    always_comb begin
        base = (cfg_half == '0) ? HW'(1) : {1'b0, cfg_half};
        dbl  = base << 1;
        unique case (cls)
            RATE_SHORT: half = (base < SMIN) ? SMIN : base;
            RATE_LONG:  half = base;
            RATE_READ:  half = (dbl < RMIN) ? RMIN : dbl;
            default:    half = base;
        endcase
    end

endmodule

// File: rtl/dbi_byte_shifter.sv
`timescale 1ns/1ps
module dbi_byte_shifter #(
    parameter int HW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    tx_byte,
    input  logic [HW-1:0] half,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          active,
    output logic          done,
    output logic [7:0]    rx_byte
);
    logic [7:0]    sh_q;
    logic [HW-1:0] half_q;
    logic [HW-1:0] cnt_q;
    logic [2:0]    bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= 8'h00;
            half_q  <= HW'(1);
            cnt_q   <= '0;
            bit_q   <= 3'd0;
            sclk    <= 1'b0;
            active  <= 1'b0;
            done    <= 1'b0;
            rx_byte <= 8'h00;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sh_q   <= tx_byte;
                half_q <= half;
                cnt_q  <= '0;
                bit_q  <= 3'd0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (cnt_q == half_q - HW'(1)) begin
                    cnt_q <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk  <= 1'b0;
                        sh_q  <= {sh_q[6:0], 1'b0};
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + HW'(1);
                end
            end
        end
    end

    assign mosi = sh_q[7];

    p_clk_rests_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk);
    p_half_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |-> (half != '0));

endmodule

// File: rtl/dbi_cmd_engine.sv
`timescale 1ns/1ps
module dbi_cmd_engine
    import dbi_pkg::*;
#(
    parameter int LEN_W          = 8,
    parameter int DIV_W          = 8,
    parameter int SHORT_HALF_MIN = 10,
    parameter int READ_HALF_MIN  = 50,
    parameter int SHORT_XFER_MAX = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_cmd,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_rd,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic [7:0]       par_data,
    input  logic             par_valid,
    output logic             par_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n,
    output logic             spi_dc
);
    localparam int HW = DIV_W + 1;

    eng_state_t st, st_nx;

    logic            sh_start, sh_active, sh_done;
    logic [7:0]      sh_byte, sh_rx;
    rate_cls_t       sh_cls;
    logic [HW-1:0]   sh_half;

    logic [LEN_W-1:0] len_q, cnt_q;
    logic             rd_q, dmy_q, first_q, err_q, rdv_q;
    logic [7:0]       prev_q, rdd_q;

    logic req_in_tbl, req_route_rd, req_dmy, req_bad, long_q;

    always_comb begin
        req_in_tbl   = is_read_cmd(req_cmd);
        req_dmy      = has_dummy_clk(req_cmd);
        req_route_rd = req_rd | req_in_tbl;
        req_bad      = req_route_rd &&
                       (!req_in_tbl || (req_len == '0) ||
                        (req_dmy && (req_len != LEN_W'(3)) && (req_len != LEN_W'(4))));
        long_q       = 32'(len_q) > 32'(SHORT_XFER_MAX);
    end

    dbi_rate_sel #(
        .DIV_W          (DIV_W),
        .SHORT_HALF_MIN (SHORT_HALF_MIN),
        .READ_HALF_MIN  (READ_HALF_MIN)
    ) u_rate (
        .cfg_half (cfg_half_div),
        .cls      (sh_cls),
        .half     (sh_half)
    );

    dbi_byte_shifter #(.HW(HW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_byte),
        .half    (sh_half),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .active  (sh_active),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    // Next state and the shifter launch that goes with each transition.
    always_comb begin
        st_nx    = st;
        sh_start = 1'b0;
        sh_byte  = 8'h00;
        sh_cls   = RATE_SHORT;
        unique case (st)
            ST_IDLE: begin
                if (req_valid && !req_bad) begin
                    st_nx    = ST_CMD;
                    sh_start = 1'b1;
                    sh_byte  = req_cmd;
                end
            end
            ST_CMD: begin
                if (sh_done) begin
                    if (rd_q) begin
                        st_nx    = ST_RX;
                        sh_start = 1'b1;
                        sh_cls   = RATE_READ;
                    end else if (len_q == '0) begin
                        st_nx = ST_FIN;
                    end else begin
                        st_nx = ST_PWAIT;
                    end
                end
            end
            ST_PWAIT: begin
                if (par_valid) begin
                    st_nx    = ST_PARAM;
                    sh_start = 1'b1;
                    sh_byte  = par_data;
                    sh_cls   = long_q ? RATE_LONG : RATE_SHORT;
                end
            end
            ST_PARAM: begin
                if (sh_done) st_nx = (cnt_q == '0) ? ST_FIN : ST_PWAIT;
            end
            ST_RX: begin
                if (sh_done) begin
                    if (cnt_q == '0) begin
                        st_nx = ST_FIN;
                    end else begin
                        sh_start = 1'b1;
                        sh_cls   = RATE_READ;
                    end
                end
            end
            ST_FIN:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Request latch, byte counter and read realignment.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            dmy_q   <= 1'b0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
            rdv_q   <= 1'b0;
            prev_q  <= 8'h00;
            rdd_q   <= 8'h00;
        end else begin
            err_q <= 1'b0;
            rdv_q <= 1'b0;
            if (st == ST_IDLE) begin
                if (req_valid) begin
                    if (req_bad) begin
                        err_q <= 1'b1;
                    end else begin
                        len_q   <= req_len;
                        rd_q    <= req_route_rd;
                        dmy_q   <= req_dmy;
                        first_q <= 1'b1;
                    end
                end
            end else if (st == ST_CMD) begin
                if (sh_done)
                    cnt_q <= rd_q ? (len_q + {{(LEN_W-1){1'b0}}, dmy_q} - LEN_W'(1))
                                  : len_q;
            end else if (st == ST_PWAIT) begin
                if (par_valid) cnt_q <= cnt_q - LEN_W'(1);
            end else if (st == ST_RX) begin
                if (sh_done) begin
                    first_q <= 1'b0;
                    prev_q  <= sh_rx;
                    if (!dmy_q) begin
                        rdd_q <= sh_rx;
                        rdv_q <= 1'b1;
                    end else if (!first_q) begin
                        rdd_q <= {prev_q[6:0], sh_rx[7]};
                        rdv_q <= 1'b1;
                    end
                    if (cnt_q != '0) cnt_q <= cnt_q - LEN_W'(1);
                end
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy      = (st != ST_IDLE);
        done      = (st == ST_FIN);
        spi_cs_n  = (st == ST_IDLE) || (st == ST_FIN);
        spi_dc    = (st == ST_PWAIT) || (st == ST_PARAM);
        par_ready = (st == ST_PWAIT);
        err       = err_q;
        rd_valid  = rdv_q;
        rd_data   = rdd_q;
    end

    p_select_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_active |-> !spi_cs_n);
    p_dc_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_active && $past(sh_active)) |-> $stable(spi_dc));
    p_start_when_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !sh_active);
    p_err_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && spi_cs_n));
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_rd_from_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(st == ST_RX));
    p_par_ready_idle_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        par_ready |-> !sh_active);

endmodule

// File: tb/dbi_cmd_engine_test.sv
`timescale 1ns/1ps
module dbi_cmd_engine_test;
    localparam int SMIN = 4;
    localparam int RMIN = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_cmd = 8'h00;
    logic [7:0] req_len = 8'h00;
    logic       req_rd = 1'b0;
    logic [7:0] cfg_half_div = 8'd1;
    logic [7:0] par_data;
    logic       par_valid = 1'b1;
    logic       par_ready, rd_valid, busy, done, err;
    logic [7:0] rd_data;
    logic       spi_sclk, spi_mosi, spi_miso, spi_cs_n, spi_dc;

    dbi_cmd_engine #(
        .LEN_W(8), .DIV_W(8), .SHORT_HALF_MIN(SMIN), .READ_HALF_MIN(RMIN), .SHORT_XFER_MAX(64)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_len(req_len), .req_rd(req_rd), .cfg_half_div(cfg_half_div),
        .par_data(par_data), .par_valid(par_valid), .par_ready(par_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
    );

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    // Display-side model state.
    logic [7:0] cap_b [0:127];
    logic       cap_dc[0:127];
    int         cap_hi[0:127];
    logic [7:0] pbuf  [0:127];
    logic [7:0] rd_out[0:511];
    int ncap = 0, nbit = 0, kedge = 0, t_rise = 0;
    int ncs_fall = 0, ncs_rise = 0, dc_bad = 0;
    int ndone = 0, nerr = 0, nrd = 0;
    logic [7:0] shreg = 8'h00;
    logic       dcb = 1'b0;
    logic       cur_dmy = 1'b0;
    logic [7:0] cur_seed = 8'h00;
    logic       busy_after = 1'b0;

    function automatic logic [7:0] resp_byte(input int i, input logic [7:0] s);
        return 8'h3C ^ 8'(i * 29) ^ s;
    endfunction

    function automatic logic resp_bit(input int k, input logic d, input logic [7:0] s);
        int j;
        logic [7:0] b;
        if (k < 8) return 1'b0;
        j = k - 8;
        if (d) begin
            if (j == 0) return 1'b1;
            j = j - 1;
        end
        b = resp_byte(j / 8, s);
        return b[7 - (j % 8)];
    endfunction

    function automatic logic [7:0] tbl_cmd(input int i);
        case (i)
            0: return 8'h04;  1: return 8'h06;  2: return 8'h07;  3: return 8'h08;
            4: return 8'h09;  5: return 8'h0A;  6: return 8'h0B;  7: return 8'h0C;
            8: return 8'h0D;  9: return 8'h0E; 10: return 8'h0F; 11: return 8'h2E;
           12: return 8'h3E; 13: return 8'h45; 14: return 8'h52; 15: return 8'h54;
           16: return 8'h56; 17: return 8'h5F; 18: return 8'hA1; default: return 8'hA8;
        endcase
    endfunction

    always_comb spi_miso = resp_bit(kedge, cur_dmy, cur_seed);
    assign par_data = (ncap >= 1 && ncap <= 128) ? pbuf[ncap-1] : 8'h00;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge spi_cs_n or posedge spi_sclk) begin
        if (!spi_sclk) begin
            ncap = 0; nbit = 0; kedge = 0;
            ncs_fall = ncs_fall + 1;
        end else if (!spi_cs_n) begin
            shreg = {shreg[6:0], spi_mosi};
            if (nbit == 0) dcb = spi_dc;
            else if (spi_dc != dcb) dc_bad = dc_bad + 1;
            t_rise = cyc;
            kedge = kedge + 1;
            nbit = nbit + 1;
            if (nbit == 8) begin
                if (ncap < 128) begin
                    cap_b[ncap]  = shreg;
                    cap_dc[ncap] = dcb;
                end
                nbit = 0;
                ncap = ncap + 1;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (nbit == 0) begin
                if (ncap >= 1 && ncap <= 128) cap_hi[ncap-1] = cyc - t_rise;
            end else if (ncap < 128) begin
                cap_hi[ncap] = cyc - t_rise;
            end
        end
    end

    always @(posedge spi_cs_n) ncs_rise = ncs_rise + 1;

    always @(negedge clk) begin
        if (rd_valid) begin
            rd_out[nrd % 512] = rd_data;
            nrd = nrd + 1;
        end
        if (done) ndone = ndone + 1;
        if (err)  nerr  = nerr + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int f0, r0, d0, e0, n0, b0;

    task automatic run(input logic [7:0] cmd, input int len, input logic rd,
                       input int cfg, input logic [7:0] seed);
        @(negedge clk);
        for (int i = 0; i < 128; i++) pbuf[i] = 8'(cmd * 3 + i * 17) ^ seed;
        f0 = ncs_fall; r0 = ncs_rise; d0 = ndone; e0 = nerr; n0 = nrd; b0 = dc_bad;
        cur_dmy  = (cmd == 8'h04) || (cmd == 8'h09);
        cur_seed = seed;
        cfg_half_div = 8'(cfg);
        req_cmd = cmd; req_len = 8'(len); req_rd = rd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_after = busy;
        for (int t = 0; t < 30000; t++) begin
            if (ndone != d0 || nerr != e0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_write(input logic [7:0] cmd, input int len, input int cfg);
        int h, bad, wbad, pw;
        h = (cfg == 0) ? 1 : cfg;
        pw = (len > 64) ? h : maxi(SMIN, h);
        chk(ndone - d0 == 1 && nerr == e0, "R12 done pulse on write", ndone - d0, 1);
        chk(busy_after == 1'b1, "R12 busy after accept", int'(busy_after), 1);
        chk(ncs_fall - f0 == 1 && ncs_rise - r0 == 1, "R4 one select window",
            (ncs_fall - f0) * 10 + (ncs_rise - r0), 11);
        chk(ncap == 1 + len, "R3 bytes on bus", ncap, 1 + len);
        chk(cap_b[0] == cmd && cap_dc[0] == 1'b0, "R2 command byte", int'(cap_b[0]), int'(cmd));
        bad = 0; wbad = 0;
        for (int i = 0; i < len && i < 127; i++) begin
            if (cap_b[1+i] != pbuf[i] || cap_dc[1+i] != 1'b1) bad = bad + 1;
            if (cap_hi[1+i] != pw) wbad = wbad + 1;
        end
        chk(bad == 0, "R3 parameter bytes and D/C", bad, 0);
        chk(dc_bad == b0, "R3 D/C steady in byte", dc_bad - b0, 0);
        chk(cap_hi[0] == maxi(SMIN, h), "R10 command clock width", cap_hi[0], maxi(SMIN, h));
        chk(wbad == 0, "R10 parameter clock width", wbad, 0);
        chk(nrd == n0, "R5 no read strobes on write", nrd - n0, 0);
    endtask

    task automatic check_read(input logic [7:0] cmd, input int n, input int cfg,
                              input logic [7:0] seed);
        int h, dm, bad, mbad, wbad;
        string tg;
        h = (cfg == 0) ? 1 : cfg;
        dm = ((cmd == 8'h04) || (cmd == 8'h09)) ? 1 : 0;
        tg = (dm != 0) ? "R8 realigned read data" : "R5 read data";
        chk(ndone - d0 == 1 && nerr == e0, "R12 done pulse on read", ndone - d0, 1);
        chk(busy_after == 1'b1, "R12 busy after accept", int'(busy_after), 1);
        chk(ncs_fall - f0 == 1 && ncs_rise - r0 == 1, "R4 one select window",
            (ncs_fall - f0) * 10 + (ncs_rise - r0), 11);
        chk(ncap == 1 + n + dm, (dm != 0) ? "R8 received byte count" : "R5 received byte count",
            ncap, 1 + n + dm);
        chk(cap_b[0] == cmd && cap_dc[0] == 1'b0, "R2 command byte", int'(cap_b[0]), int'(cmd));
        chk(cap_hi[0] == maxi(SMIN, h), "R10 command clock width", cap_hi[0], maxi(SMIN, h));
        mbad = 0; wbad = 0;
        for (int i = 1; i < 1 + n + dm && i < 128; i++) begin
            if (cap_b[i] != 8'h00 || cap_dc[i] != 1'b0) mbad = mbad + 1;
            if (cap_hi[i] != maxi(RMIN, 2 * h)) wbad = wbad + 1;
        end
        chk(mbad == 0, "R5 data-out low and D/C low while receiving", mbad, 0);
        chk(wbad == 0, "R11 read clock width", wbad, 0);
        chk(nrd - n0 == n, "R5 read strobe count", nrd - n0, n);
        bad = 0;
        for (int i = 0; i < n; i++)
            if (rd_out[(n0 + i) % 512] != resp_byte(i, seed)) bad = bad + 1;
        chk(bad == 0, tg, bad, 0);
    endtask

    task automatic check_err(input string tg);
        chk(nerr - e0 == 1, tg, nerr - e0, 1);
        chk(ndone == d0 && ncs_fall == f0, "R12 reject leaves bus idle",
            (ndone - d0) + (ncs_fall - f0), 0);
        chk(busy_after == 1'b0, "R12 busy stays low on reject", int'(busy_after), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_dc == 1'b0, "R1 bus idle in reset",
            {spi_cs_n, spi_sclk, spi_dc}, 3'b100);
        chk(!busy && !done && !err && !par_ready && !rd_valid, "R1 status low in reset",
            {busy, done, err, par_ready, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R3/R10 write sweep over divider and count
        foreach (cap_hi[i]) cap_hi[i] = 0;
        for (int c = 0; c < 4; c++) begin
            for (int l = 0; l < 5; l++) begin
                int cfg;
                cfg = (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 2 : 5;
                run(8'(8'h20 + l), l, 1'b0, cfg, 8'(c * 16 + l));
                check_write(8'(8'h20 + l), l, cfg);
            end
        end
        // R10 boundary: 64 stays slow, 65 runs at host rate
        run(8'h2C, 64, 1'b0, 1, 8'h11);
        check_write(8'h2C, 64, 1);
        run(8'h2C, 65, 1'b0, 1, 8'h22);
        check_write(8'h2C, 65, 1);
        run(8'h2C, 65, 1'b0, 2, 8'h23);
        check_write(8'h2C, 65, 2);

        // R5/R11 reads over the command table (dummy commands handled below)
        for (int i = 0; i < 20; i++) begin
            logic [7:0] cm;
            int nn, cf;
            cm = tbl_cmd(i);
            nn = 1 + (i % 3);
            cf = ((i % 2) == 1) ? 1 : 4;
            if (cm != 8'h04 && cm != 8'h09) begin
                run(cm, nn, 1'b1, cf, 8'(i * 7));
                check_read(cm, nn, cf, 8'(i * 7));
            end
        end

        // R6 routing of a write request for a table command
        run(8'h0A, 2, 1'b0, 1, 8'h5A);
        check_read(8'h0A, 2, 1, 8'h5A);
        // R6 read of a non-table command is rejected
        run(8'h2C, 1, 1'b1, 1, 8'h00);
        check_err("R6 non-table read rejected");
        // R7 zero-length read rejected
        run(8'h0C, 0, 1'b1, 1, 8'h00);
        check_err("R7 zero-length read rejected");

        // R8 dummy-clock reads
        run(8'h04, 3, 1'b1, 2, 8'h81);
        check_read(8'h04, 3, 2, 8'h81);
        run(8'h09, 4, 1'b1, 2, 8'h42);
        check_read(8'h09, 4, 2, 8'h42);
        run(8'h04, 4, 1'b1, 4, 8'hE7);
        check_read(8'h04, 4, 4, 8'hE7);
        run(8'h09, 3, 1'b0, 1, 8'h18);
        check_read(8'h09, 3, 1, 8'h18);

        // R9 dummy-clock reads with illegal counts
        run(8'h04, 2, 1'b1, 1, 8'h00);
        check_err("R9 dummy read N=2 rejected");
        run(8'h04, 5, 1'b1, 1, 8'h00);
        check_err("R9 dummy read N=5 rejected");
        run(8'h09, 1, 1'b1, 1, 8'h00);
        check_err("R9 dummy read N=1 rejected");

        // engine still usable after rejects
        run(8'h36, 1, 1'b0, 3, 8'h3D);
        check_write(8'h36, 1, 3);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        wait (cyc > 190000);
        nchk = nchk + 1;
        nfail = nfail + 1;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule